// File: doc/BRIEF.md
# Software Flow-Controlled Serial Byte Buffer

This block sits between a byte-wide serial receiver/transmitter pair and a host. Bytes coming from the line are kept in a circular receive store until the host takes them. Bytes the host queues wait in a circular transmit store until the transmitter accepts them. Both host sides and the transmitter side use valid/ready byte handshakes. The receiver side offers one byte per cycle with `rx_valid` and is never stalled.

The block applies software flow control in both directions. When the receive store nears full, it schedules a stop byte (`xoff_code`) toward the remote end. Once the host has drained the store, it schedules a resume byte (`xon_code`). A scheduled flow byte goes out ahead of any queued data. A received stop byte halts the drain of queued data, and a received resume byte restarts it. Both codes are configuration inputs. A code of zero disables matching, and a zero `xoff_code` also disables stop-byte generation.

Line errors and receive-store overflow collect in a sticky error register. The host sees this register next to the head byte, and each host read clears it.

Top module: `sflow_buffer`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) empties both stores, clears the error register, clears the halted state and clears all flow-byte state. After reset, `host_rd_valid` is 0, `tx_valid` is 0, `host_wr_ready` is 1 and `host_rd_err` is 0.
- R2: Stored received bytes reach the host in arrival order, including across the wrap of the circular store. `host_rd_valid` is 1 exactly when at least one byte is held (up to RX_DEPTH = 80). `host_rd_data` shows the oldest byte. A byte is removed in a cycle where both `host_rd_valid` and `host_rd_ready` are 1.
- R3: The transmit store holds up to TX_DEPTH = 140 bytes. `host_wr_ready` is 0 while it is full, and a write offered then is ignored. Queued bytes leave on `tx_data` in write order, one per cycle with `tx_valid` and `tx_ready` both 1.
- R4: A byte to be stored that arrives while the receive store already holds 80 bytes is discarded, and bit 3 of the error register is set.
- R5: In every cycle with `rx_valid`, `rx_err` (bit 0 framing, bit 1 parity, bit 2 line overrun) is ORed into bits 2:0 of the error register. `host_rd_err` shows the register. A host read clears it, but errors arriving in that same cycle are kept.
- R6: A received nonzero byte equal to `xoff_code` is not stored and halts the sending of queued data (`tx_valid` 0 when no flow byte is scheduled). A received nonzero byte equal to `xon_code` is not stored and ends the halt.
- R7: A received zero byte is always stored, even when a configured code is zero.
- R8: When a store leaves 70 or more bytes held, `xoff_code` is nonzero and no flow byte is scheduled or outstanding, a stop byte is scheduled. From the next cycle `tx_valid` is 1 with `tx_data` = `xoff_code`, ahead of queued data. Once it is accepted, the stop is outstanding and queued data flows again.
- R9: While a stop is outstanding, a host read at a moment when 10 or fewer bytes are held schedules a resume byte. From the next cycle `tx_valid` is 1 with `tx_data` = `xon_code`. Once it is accepted, the flow state is idle and a later crossing of 70 schedules a new stop byte.
- R10: With `xoff_code` zero, no stop byte is ever generated, even with the receive store full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| xon_code | input | 8 | Resume byte value (0 = no match) |
| xoff_code | input | 8 | Stop byte value (0 = no match, no generation) |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | Line errors with the byte: framing, parity, overrun |
| host_rd_valid | output | 1 | Receive store not empty |
| host_rd_data | output | 8 | Oldest received byte |
| host_rd_err | output | 4 | Sticky error register, bit 3 = store overflow |
| host_rd_ready | input | 1 | Host takes the head byte |
| host_wr_valid | input | 1 | Host offers a byte to send |
| host_wr_data | input | 8 | Byte to send |
| host_wr_ready | output | 1 | Transmit store has room |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Flow byte or queued data byte |
| tx_ready | input | 1 | Transmitter accepts the byte |

## Verification
Two events can meet in one cycle here. The first is a host read that clears the error register while a received byte carries a new line error. The bench provokes this by holding `host_rd_ready` in the same cycle it presents an errored byte. It then requires that only the new error bit survives, and that this bit is shown beside the next head byte. The second is the threshold crossings, which are counted exactly. The 70th held byte must bring the stop byte out while the 69th does not. The resume byte must follow the read taken with 10 bytes held and not the one taken with 11. After the resume, the bench refills the store to confirm that a stop byte is scheduled again.

// File: rtl/sfb_pkg.sv
// Package: shared types for the flow-controlled serial buffer.
// Holds the flow-byte state encoding and the error register bit positions.
package sfb_pkg;

    // Flow-byte scheduling state
    typedef enum logic [1:0] {
        FL_IDLE      = 2'd0,
        FL_PEND_XOFF = 2'd1,
        FL_HELD_OFF  = 2'd2,
        FL_PEND_XON  = 2'd3
    } flow_st_t;

    localparam int ERR_W      = 4;
    localparam int LINE_ERR_W = ERR_W - 1;
    localparam int ERR_DROP   = 3;

endpackage

// File: rtl/sfb_ring.sv
// Module: sfb_ring
// Circular byte store with show-ahead head output and an occupancy count.
// Assumes the caller never pushes when full nor pops when empty.
module sfb_ring #(
    parameter int DEPTH = 80,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Storage write; no reset needed on data cells
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy update with wrap at the last cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            end
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Status and head byte
    always_comb begin
        head  = mem[rd_ptr];
        full  = (count == CMAX);
        empty = (count == '0);
    end

endmodule

// File: rtl/sfb_rx_ctrl.sv
// Module: sfb_rx_ctrl
// Classifies each received byte as stop code, resume code or data.
// Keeps the halted flag and the sticky error register.
// Assumes a zero byte never matches a code and a stop match wins over resume.
module sfb_rx_ctrl #(
    parameter int DW = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rx_valid,
    input  logic [DW-1:0]                  rx_data,
    input  logic [sfb_pkg::LINE_ERR_W-1:0] rx_err,
    input  logic [DW-1:0]                  xon_code,
    input  logic [DW-1:0]                  xoff_code,
    input  logic                           ring_full,
    input  logic                           host_pop,
    output logic                           store,
    output logic                           paused,
    output logic [sfb_pkg::ERR_W-1:0]      err_q
);

    logic hit_xoff;
    logic hit_xon;
    logic keep;
    logic drop;

    // Byte classification and store/drop decision
    always_comb begin
        hit_xoff = rx_valid && (rx_data != '0) && (rx_data == xoff_code);
        hit_xon  = rx_valid && (rx_data != '0) && (rx_data == xon_code) && !hit_xoff;
        keep     = rx_valid && !hit_xoff && !hit_xon;
        store    = keep && !ring_full;
        drop     = keep && ring_full;
    end

    // Halted flag: set by stop code, cleared by resume code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused <= 1'b0;
        end else if (hit_xoff) begin
            paused <= 1'b1;
        end else if (hit_xon) begin
            paused <= 1'b0;
        end
    end

    // Sticky errors: cleared by a host read, new errors in that cycle kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (host_pop ? '0 : err_q)
                   | {drop, (rx_valid ? rx_err : '0)};
        end
    end

endmodule

// File: rtl/sfb_flow_ctrl.sv
// Module: sfb_flow_ctrl
// Schedules stop/resume bytes from receive occupancy thresholds and
// arbitrates the transmitter between a scheduled flow byte and queued data.
// Assumes rx_count is the occupancy before this cycle's store and read.
module sfb_flow_ctrl #(
    parameter int DW       = 8,
    parameter int RX_DEPTH = 80,
    parameter int RX_HI    = 70,
    parameter int RX_LO    = 10,
    localparam int CW      = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic              host_pop,
    input  logic [CW-1:0]     rx_count,
    input  logic [DW-1:0]     xon_code,
    input  logic [DW-1:0]     xoff_code,
    input  logic              paused,
    input  logic              txq_empty,
    input  logic [DW-1:0]     txq_head,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_data,
    output logic              txq_pop,
    output sfb_pkg::flow_st_t flow_st
);
    import sfb_pkg::*;

    localparam logic [CW:0]   HI_V = (CW + 1)'(RX_HI);
    localparam logic [CW-1:0] LO_V = CW'(RX_LO);

    logic [CW:0] post_cnt;
    logic        pend;
    logic        arm_off;
    logic        arm_on;
    flow_st_t    st_nxt;

    // Occupancy after this cycle and threshold triggers
    always_comb begin
        post_cnt = {1'b0, rx_count} + {{CW{1'b0}}, store} - {{CW{1'b0}}, host_pop};
        arm_off  = store && (post_cnt >= HI_V) && (xoff_code != '0);
        arm_on   = host_pop && (rx_count <= LO_V);
    end

    // Transmit arbitration: flow byte first, then data unless halted
    always_comb begin
        pend     = (flow_st == FL_PEND_XOFF) || (flow_st == FL_PEND_XON);
        tx_valid = pend || (!paused && !txq_empty);
        tx_data  = pend ? ((flow_st == FL_PEND_XON) ? xon_code : xoff_code) : txq_head;
        txq_pop  = !pend && !paused && !txq_empty && tx_ready;
    end

    // Next flow state
    always_comb begin
        st_nxt = flow_st;
        case (flow_st)
            FL_IDLE:      if (arm_off)  st_nxt = FL_PEND_XOFF;
            FL_PEND_XOFF: if (tx_ready) st_nxt = FL_HELD_OFF;
            FL_HELD_OFF:  if (arm_on)   st_nxt = FL_PEND_XON;
            FL_PEND_XON:  if (tx_ready) st_nxt = FL_IDLE;
            default:                    st_nxt = FL_IDLE;
        endcase
    end

    // Flow state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flow_st <= FL_IDLE;
        end else begin
            flow_st <= st_nxt;
        end
    end

endmodule

// File: rtl/sflow_buffer.sv
// Module: sflow_buffer (top)
// Receive and transmit circular stores with software flow control.
// Assumes the receiver cannot be stalled and both codes are held stable.
module sflow_buffer #(
    parameter int DW       = 8,
    parameter int RX_DEPTH = 80,
    parameter int TX_DEPTH = 140,
    parameter int RX_HI    = 70,
    parameter int RX_LO    = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [DW-1:0]                  xon_code,
    input  logic [DW-1:0]                  xoff_code,
    input  logic                           rx_valid,
    input  logic [DW-1:0]                  rx_data,
    input  logic [sfb_pkg::LINE_ERR_W-1:0] rx_err,
    output logic                           host_rd_valid,
    output logic [DW-1:0]                  host_rd_data,
    output logic [sfb_pkg::ERR_W-1:0]      host_rd_err,
    input  logic                           host_rd_ready,
    input  logic                           host_wr_valid,
    input  logic [DW-1:0]                  host_wr_data,
    output logic                           host_wr_ready,
    output logic                           tx_valid,
    output logic [DW-1:0]                  tx_data,
    input  logic                           tx_ready
);

    localparam int RX_CW = $clog2(RX_DEPTH + 1);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);

    logic               rx_store;
    logic               rx_full;
    logic               rx_empty;
    logic [RX_CW-1:0]   rx_count;
    logic               host_pop;
    logic               paused;
    logic               txq_push;
    logic               txq_pop;
    logic               txq_full;
    logic               txq_empty;
    logic [TX_CW-1:0]   txq_count;
    logic [DW-1:0]      txq_head;
    sfb_pkg::flow_st_t  flow_st;

    // Host-side handshakes
    always_comb begin
        host_rd_valid = !rx_empty;
        host_pop      = host_rd_valid && host_rd_ready;
        host_wr_ready = !txq_full;
        txq_push      = host_wr_valid && host_wr_ready;
    end

    sfb_rx_ctrl #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_err    (rx_err),
        .xon_code  (xon_code),
        .xoff_code (xoff_code),
        .ring_full (rx_full),
        .host_pop  (host_pop),
        .store     (rx_store),
        .paused    (paused),
        .err_q     (host_rd_err)
    );

    sfb_ring #(.DEPTH(RX_DEPTH), .W(DW)) u_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_store),
        .push_data (rx_data),
        .pop       (host_pop),
        .head      (host_rd_data),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    sfb_ring #(.DEPTH(TX_DEPTH), .W(DW)) u_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (txq_push),
        .push_data (host_wr_data),
        .pop       (txq_pop),
        .head      (txq_head),
        .count     (txq_count),
        .full      (txq_full),
        .empty     (txq_empty)
    );

    sfb_flow_ctrl #(
        .DW(DW), .RX_DEPTH(RX_DEPTH), .RX_HI(RX_HI), .RX_LO(RX_LO)
    ) u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (rx_store),
        .host_pop  (host_pop),
        .rx_count  (rx_count),
        .xon_code  (xon_code),
        .xoff_code (xoff_code),
        .paused    (paused),
        .txq_empty (txq_empty),
        .txq_head  (txq_head),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .txq_pop   (txq_pop),
        .flow_st   (flow_st)
    );

endmodule

// File: rtl/sfb_checker.sv
// Module: sfb_checker
// Temporal properties of the flow-controlled buffer, bound to the top.
module sfb_checker #(
    parameter int DW       = 8,
    parameter int TX_DEPTH = 140,
    localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rx_valid,
    input logic [DW-1:0]             rx_data,
    input logic [DW-1:0]             xon_code,
    input logic [DW-1:0]             xoff_code,
    input logic                      host_rd_valid,
    input logic                      host_rd_ready,
    input logic [sfb_pkg::ERR_W-1:0] host_rd_err,
    input logic                      tx_valid,
    input logic                      tx_ready,
    input logic                      paused,
    input sfb_pkg::flow_st_t         flow_st,
    input logic                      rx_full,
    input logic [TX_CW-1:0]          txq_count
);
    import sfb_pkg::*;

    AST_TXQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        txq_count <= TX_CW'(TX_DEPTH)); // R3

    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_full &&
        ((rx_data == '0) || ((rx_data != xon_code) && (rx_data != xoff_code)))
        |=> host_rd_err[ERR_DROP]); // R4

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !(host_rd_valid && host_rd_ready) |=> rx_full); // R4

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_valid && host_rd_ready && !rx_valid |=> host_rd_err == '0); // R5

    AST_PAUSE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        paused && (flow_st != FL_PEND_XOFF) && (flow_st != FL_PEND_XON)
        |-> !tx_valid); // R6

    AST_XON_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_st == FL_PEND_XON) && tx_ready |=> flow_st == FL_IDLE); // R9

endmodule

bind sflow_buffer sfb_checker #(.DW(DW), .TX_DEPTH(TX_DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .xon_code      (xon_code),
    .xoff_code     (xoff_code),
    .host_rd_valid (host_rd_valid),
    .host_rd_ready (host_rd_ready),
    .host_rd_err   (host_rd_err),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .paused        (paused),
    .flow_st       (flow_st),
    .rx_full       (rx_full),
    .txq_count     (txq_count)
);

// File: tb/sflow_buffer_tb_top.sv
// Directed bench for sflow_buffer: one task per scenario, each self-checking.
module sflow_buffer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] xon_code, xoff_code;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic [2:0] rx_err;
    logic       host_rd_valid;
    logic [7:0] host_rd_data;
    logic [3:0] host_rd_err;
    logic       host_rd_ready;
    logic       host_wr_valid;
    logic [7:0] host_wr_data;
    logic       host_wr_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sflow_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .xon_code(xon_code), .xoff_code(xoff_code),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
        .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
        .host_rd_err(host_rd_err), .host_rd_ready(host_rd_ready),
        .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
        .host_wr_ready(host_wr_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [7:0] on_c, input logic [7:0] off_c);
        xon_code = on_c; xoff_code = off_c;
        rx_valid = 0; rx_data = 0; rx_err = 0;
        host_rd_ready = 0; host_wr_valid = 0; host_wr_data = 0; tx_ready = 0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic rx_byte(input logic [7:0] d, input logic [2:0] e);
        rx_valid = 1; rx_data = d; rx_err = e;
        step();
        rx_valid = 0; rx_err = 0;
    endtask

    task automatic host_write(input logic [7:0] d);
        host_wr_valid = 1; host_wr_data = d;
        step();
        host_wr_valid = 0;
    endtask

    task automatic host_read(input logic [7:0] exp, input string req);
        chk(host_rd_valid && host_rd_data == exp, req, int'(host_rd_data), int'(exp));
        host_rd_ready = 1;
        step();
        host_rd_ready = 0;
    endtask

    task automatic t_reset();
        do_reset(8'h11, 8'h13);
        chk(!host_rd_valid, "R1 rd_valid", int'(host_rd_valid), 0);
        chk(!tx_valid, "R1 tx_valid", int'(tx_valid), 0);
        chk(host_wr_ready, "R1 wr_ready", int'(host_wr_ready), 1);
        chk(host_rd_err == 0, "R1 err", int'(host_rd_err), 0);
    endtask

    task automatic t_tx_full();
        do_reset(8'h11, 8'h13);
        for (int i = 0; i < 140; i++) host_write(8'(i));
        chk(!host_wr_ready, "R3 wr_ready when full", int'(host_wr_ready), 0);
        host_write(8'hFF);
        tx_ready = 1;
        for (int i = 0; i < 140; i++) begin
            chk(tx_valid && tx_data == 8'(i), "R3 tx order", int'(tx_data), i);
            step();
        end
        chk(!tx_valid, "R3 extra write ignored", int'(tx_valid), 0);
        tx_ready = 0;
    endtask

    task automatic t_overflow();
        do_reset(8'h00, 8'h00);
        for (int i = 0; i < 80; i++) rx_byte(8'(i + 32), 3'b000);
        chk(!tx_valid, "R10 no stop byte with zero code", int'(tx_valid), 0);
        rx_byte(8'hEE, 3'b000);
        chk(host_rd_err == 4'b1000, "R4 drop bit", int'(host_rd_err), 8);
        for (int i = 0; i < 80; i++) host_read(8'(i + 32), "R2 rx order");
        chk(!host_rd_valid, "R4 dropped byte absent", int'(host_rd_valid), 0);
        rx_byte(8'h61, 3'b000); rx_byte(8'h62, 3'b000); rx_byte(8'h63, 3'b000);
        host_read(8'h61, "R2 wrap");
        host_read(8'h62, "R2 wrap");
        host_read(8'h63, "R2 wrap");
        chk(!host_rd_valid, "R2 empty", int'(host_rd_valid), 0);
    endtask

    task automatic t_errors();
        do_reset(8'h11, 8'h13);
        rx_byte(8'h41, 3'b101);
        chk(host_rd_err == 4'b0101, "R5 errors ORed", int'(host_rd_err), 5);
        host_read(8'h41, "R5 data");
        chk(host_rd_err == 0, "R5 cleared by read", int'(host_rd_err), 0);
        rx_byte(8'h43, 3'b000);
        host_rd_ready = 1; rx_valid = 1; rx_data = 8'h44; rx_err = 3'b010;
        step();
        host_rd_ready = 0; rx_valid = 0; rx_err = 0;
        chk(host_rd_err == 4'b0010, "R5 same-cycle error kept", int'(host_rd_err), 2);
        host_read(8'h44, "R5 next head");
    endtask

    task automatic t_pause();
        do_reset(8'h11, 8'h13);
        host_write(8'hA1); host_write(8'hA2);
        chk(tx_valid && tx_data == 8'hA1, "R3 head offered", int'(tx_data), 'hA1);
        rx_byte(8'h13, 3'b000);
        chk(!tx_valid, "R6 stop halts data", int'(tx_valid), 0);
        chk(!host_rd_valid, "R6 stop code not stored", int'(host_rd_valid), 0);
        tx_ready = 1; step(); tx_ready = 0;
        rx_byte(8'h11, 3'b000);
        chk(tx_valid && tx_data == 8'hA1, "R6 resume, nothing lost", int'(tx_data), 'hA1);
        chk(!host_rd_valid, "R6 resume code not stored", int'(host_rd_valid), 0);
    endtask

    task automatic t_zero();
        do_reset(8'h00, 8'h13);
        rx_byte(8'h00, 3'b000);
        host_read(8'h00, "R7 zero stored");
        do_reset(8'h11, 8'h00);
        rx_byte(8'h00, 3'b000);
        host_read(8'h00, "R7 zero stored, zero stop code");
    endtask

    task automatic t_flow();
        do_reset(8'h11, 8'h13);
        host_write(8'h55);
        for (int i = 0; i < 69; i++) rx_byte(8'h80 | 8'(i), 3'b000);
        chk(tx_valid && tx_data == 8'h55, "R8 no stop at 69", int'(tx_data), 'h55);
        rx_byte(8'h80 | 8'd69, 3'b000);
        chk(tx_valid && tx_data == 8'h13, "R8 stop ahead of data", int'(tx_data), 'h13);
        tx_ready = 1; step();
        chk(tx_valid && tx_data == 8'h55, "R8 data after stop", int'(tx_data), 'h55);
        step(); tx_ready = 0;
        chk(!tx_valid, "R8 queue drained", int'(tx_valid), 0);
        for (int i = 0; i < 60; i++) host_read(8'h80 | 8'(i), "R9 drain data");
        chk(!tx_valid, "R9 no resume at 11", int'(tx_valid), 0);
        host_read(8'h80 | 8'd60, "R9 drain data");
        chk(tx_valid && tx_data == 8'h11, "R9 resume queued", int'(tx_data), 'h11);
        tx_ready = 1; step(); tx_ready = 0;
        chk(!tx_valid, "R9 resume sent", int'(tx_valid), 0);
        for (int i = 0; i < 60; i++) rx_byte(8'h40, 3'b000);
        chk(!tx_valid, "R9 no stop at 69 again", int'(tx_valid), 0);
        rx_byte(8'h40, 3'b000);
        chk(tx_valid && tx_data == 8'h13, "R9 stop re-armed", int'(tx_data), 'h13);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_tx_full();
        t_overflow();
        t_errors();
        t_pause();
        t_zero();
        t_flow();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule